// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block controls hazards for an in-order pipeline. The pipeline has several fully pipelined functional units with different latencies, and all of them share a single register-file write port. Each cycle the pipeline presents two things: the instruction sitting in decode, and the instruction waiting in issue. For each one it gives the destination register tag, the source register tags with their use flags, and, for the issuing instruction, its unit class.

The block answers within the same cycle. It raises a decode hold for write-after-read and write-after-write hazards, and also when the issue stage cannot accept a new instruction. It raises an issue hold for read-after-write hazards. It raises a separate structural hold when the write-port slot the instruction would need is already taken. When none of these applies it grants issue.

Internally it keeps one pending-write bit per register. It also keeps a ring of future writeback slots on the write port. It announces each writeback on the cycle that write occurs. A result written back in a cycle can be read by an instruction issuing in that same cycle, because the register file writes early in the cycle and reads late in it.

Top module: `hazard_scoreboard`

## Requirements
- R1: A synchronous active-high reset clears every pending-write bit and every writeback reservation. In the first cycle after reset, wb_valid is 0 and no source register counts as pending.
- R2: A valid decode instruction is held (dec_stall=1) when its destination tag has a pending write, or when it equals the destination of the valid issue-stage instruction (write-after-write).
- R3: A valid decode instruction is held when its destination tag equals a used source tag of the valid issue-stage instruction (write-after-read).
- R4: A valid decode instruction is also held whenever the issue stage holds a valid instruction that is not granted this cycle. dec_stall is 0 whenever dec_valid is 0.
- R5: A valid issue-stage instruction is held (iss_stall=1, iss_grant=0) while any of its used sources has a pending write (read-after-write).
- R6: A source whose pending write is being written back in the current cycle (wb_valid=1 and wb_tag equal to that source) does not hold issue.
- R7: A valid issue-stage instruction with no read-after-write hazard raises wp_stall and is not granted if the write-port slot L+1 cycles ahead is already reserved. Otherwise iss_grant=1. At most one of iss_stall, wp_stall and iss_grant is 1.
- R8: The unit code gives the execute latency L: 0 is integer add (L=1), 1 is load (L=3), 2 is floating-point add (L=3), and 3 uses the integer latency. A grant in cycle t produces wb_valid=1 with wb_tag equal to the granted destination in cycle t+L+1. From the cycle after the grant, the destination counts as pending.
- R9: A tag is {file, index}. Bit 5 is 1 for the floating-point file and 0 for the integer file, and bits 4:0 are the index. A pending write in one file never holds a source or destination with the same index in the other file.
- R10: A source whose use flag is 0 never causes an issue hold, whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_dst | input | 6 | Decode destination tag |
| dec_src_a | input | 6 | Decode first source tag |
| dec_use_a | input | 1 | Decode first source is read |
| dec_src_b | input | 6 | Decode second source tag |
| dec_use_b | input | 1 | Decode second source is read |
| iss_valid | input | 1 | Issue stage holds an instruction |
| iss_unit | input | 2 | Issue-stage unit class code |
| iss_dst | input | 6 | Issue destination tag |
| iss_src_a | input | 6 | Issue first source tag |
| iss_use_a | input | 1 | Issue first source is read |
| iss_src_b | input | 6 | Issue second source tag |
| iss_use_b | input | 1 | Issue second source is read |
| dec_stall | output | 1 | Hold the decode stage |
| iss_stall | output | 1 | Read-after-write hold of the issue stage |
| wp_stall | output | 1 | Write-port conflict hold |
| iss_grant | output | 1 | Issue-stage instruction issues this cycle |
| wb_valid | output | 1 | A reserved writeback occurs this cycle |
| wb_tag | output | 6 | Register written back this cycle |

## Verification
The four hold and grant outputs are combinational. They are due in the same cycle the inputs are presented, and they react to a grant only one cycle later, through the pending bits and reservations. The writeback outputs are due exactly L+1 cycles after the grant, with L taken from the unit code. The bench changes inputs on the falling edge and samples 1 ns later, then updates its behavioural queue model as the rising edge would. Every output is therefore compared against the cycle it belongs to.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        U_IADD  = 2'd0,
        U_LOAD  = 2'd1,
        U_FADD  = 2'd2,
        U_SPARE = 2'd3
    } unit_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hs_wb_ring.sv
module hs_wb_ring #(
    parameter int DEPTH = 5,
    parameter int TAG_W = 6,
    parameter int LW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [LW-1:0]    push_lat,
    input  logic [TAG_W-1:0] push_tag,
    output logic [DEPTH-1:0] busy,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag
);

    typedef struct packed {
        logic [DEPTH-1:0]            busy;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        for (int k = 0; k < DEPTH - 1; k++) begin
            ring_d.busy[k] = ring_q.busy[k+1];
            ring_d.tag[k]  = ring_q.tag[k+1];
        end
        ring_d.busy[DEPTH-1] = 1'b0;
        ring_d.tag[DEPTH-1]  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (push && (push_lat == LW'(k))) begin
                ring_d.busy[k] = 1'b1;
                ring_d.tag[k]  = push_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign busy     = ring_q.busy;
    assign wb_valid = ring_q.busy[0];
    assign wb_tag   = ring_q.tag[0];

endmodule

// File: rtl/hs_pending.sv
module hs_pending #(
    parameter int TAG_W = 6,
    parameter int NREG  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_tag,
    output logic [NREG-1:0]  pend
);

    logic [NREG-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_en) pend_d[clr_tag] = 1'b0;
        if (set_en) pend_d[set_tag] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/hs_hazard.sv
module hs_hazard #(
    parameter int TAG_W = 6,
    parameter int NREG  = 64,
    parameter int DEPTH = 5,
    parameter int LW    = 3
) (
    input  logic [NREG-1:0]  pend,
    input  logic [DEPTH-1:0] busy,
    input  logic             wb_valid,
    input  logic [TAG_W-1:0] wb_tag,
    input  logic             dec_valid,
    input  logic [TAG_W-1:0] dec_dst,
    input  logic             iss_valid,
    input  logic [LW-1:0]    iss_lat,
    input  logic [TAG_W-1:0] iss_dst,
    input  logic [TAG_W-1:0] iss_src_a,
    input  logic             iss_use_a,
    input  logic [TAG_W-1:0] iss_src_b,
    input  logic             iss_use_b,
    output logic             dec_stall,
    output logic             iss_stall,
    output logic             wp_stall,
    output logic             iss_grant
);

    logic          raw_a, raw_b, raw_any;
    logic          waw, war, slot_taken;
    logic [LW:0]   slot_idx;

    always_comb begin
        raw_a = iss_use_a && pend[iss_src_a] && !(wb_valid && (wb_tag == iss_src_a));
        raw_b = iss_use_b && pend[iss_src_b] && !(wb_valid && (wb_tag == iss_src_b));
        raw_any = raw_a || raw_b;

        slot_idx   = {1'b0, iss_lat} + 1'b1;
        slot_taken = (int'(slot_idx) < DEPTH) ? busy[slot_idx] : 1'b1;

        iss_stall = iss_valid && raw_any;
        wp_stall  = iss_valid && !raw_any && slot_taken;
        iss_grant = iss_valid && !raw_any && !slot_taken;

        waw = pend[dec_dst] || (iss_valid && (iss_dst == dec_dst));
        war = iss_valid && ((iss_use_a && (iss_src_a == dec_dst)) ||
                            (iss_use_b && (iss_src_b == dec_dst)));
        dec_stall = dec_valid && (waw || war || (iss_valid && !iss_grant));
    end

endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard #(
    parameter int IDX_W    = 5,
    parameter int LAT_IADD = 1,
    parameter int LAT_LOAD = 3,
    parameter int LAT_FADD = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [IDX_W:0]   dec_dst,
    input  logic [IDX_W:0]   dec_src_a,
    input  logic             dec_use_a,
    input  logic [IDX_W:0]   dec_src_b,
    input  logic             dec_use_b,
    input  logic             iss_valid,
    input  logic [1:0]       iss_unit,
    input  logic [IDX_W:0]   iss_dst,
    input  logic [IDX_W:0]   iss_src_a,
    input  logic             iss_use_a,
    input  logic [IDX_W:0]   iss_src_b,
    input  logic             iss_use_b,
    output logic             dec_stall,
    output logic             iss_stall,
    output logic             wp_stall,
    output logic             iss_grant,
    output logic             wb_valid,
    output logic [IDX_W:0]   wb_tag
);

    import hs_pkg::*;

    localparam int TAG_W   = IDX_W + 1;
    localparam int NREG    = 2 ** TAG_W;
    localparam int MAX_LAT = max3(LAT_IADD, LAT_LOAD, LAT_FADD);
    localparam int DEPTH   = MAX_LAT + 2;
    localparam int LW      = $clog2(DEPTH);

    logic [NREG-1:0]  pend;
    logic [DEPTH-1:0] busy;
    logic [LW-1:0]    iss_lat;

    // Decode sources are read only at issue; they take no part in the decode checks.
    logic dec_src_unused;
    assign dec_src_unused = ^{dec_src_a, dec_use_a, dec_src_b, dec_use_b};

    always_comb begin
        case (unit_e'(iss_unit))
            U_LOAD:  iss_lat = LW'(LAT_LOAD);
            U_FADD:  iss_lat = LW'(LAT_FADD);
            default: iss_lat = LW'(LAT_IADD);
        endcase
    end

    hs_hazard #(.TAG_W(TAG_W), .NREG(NREG), .DEPTH(DEPTH), .LW(LW)) u_hazard (
        .pend      (pend),
        .busy      (busy),
        .wb_valid  (wb_valid),
        .wb_tag    (wb_tag),
        .dec_valid (dec_valid),
        .dec_dst   (dec_dst),
        .iss_valid (iss_valid),
        .iss_lat   (iss_lat),
        .iss_dst   (iss_dst),
        .iss_src_a (iss_src_a),
        .iss_use_a (iss_use_a),
        .iss_src_b (iss_src_b),
        .iss_use_b (iss_use_b),
        .dec_stall (dec_stall),
        .iss_stall (iss_stall),
        .wp_stall  (wp_stall),
        .iss_grant (iss_grant)
    );

    hs_wb_ring #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LW(LW)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .push     (iss_grant),
        .push_lat (iss_lat),
        .push_tag (iss_dst),
        .busy     (busy),
        .wb_valid (wb_valid),
        .wb_tag   (wb_tag)
    );

    hs_pending #(.TAG_W(TAG_W), .NREG(NREG)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_en  (iss_grant),
        .set_tag (iss_dst),
        .clr_en  (wb_valid),
        .clr_tag (wb_tag),
        .pend    (pend)
    );

endmodule

// File: rtl/hs_checker.sv
module hs_checker #(
    parameter int TAG_W    = 6,
    parameter int NREG     = 64,
    parameter int DEPTH    = 5,
    parameter int LW       = 3,
    parameter int LAT_IADD = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             dec_valid,
    input logic [TAG_W-1:0] dec_dst,
    input logic             dec_stall,
    input logic             iss_grant,
    input logic             iss_stall,
    input logic             wp_stall,
    input logic [1:0]       iss_unit,
    input logic [TAG_W-1:0] iss_dst,
    input logic             iss_use_a,
    input logic [TAG_W-1:0] iss_src_a,
    input logic [LW-1:0]    iss_lat,
    input logic             wb_valid,
    input logic [TAG_W-1:0] wb_tag,
    input logic [NREG-1:0]  pend,
    input logic [DEPTH-1:0] busy
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!wb_valid && (pend == '0) && (busy == '0)));

    // R2
    waw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && pend[dec_dst]) |-> dec_stall);

    // R5
    raw_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_grant && iss_use_a) |-> (!pend[iss_src_a] || (wb_valid && (wb_tag == iss_src_a))));

    // R7
    slot_free_chk: assert property (@(posedge clk) disable iff (rst)
        iss_grant |-> !busy[iss_lat + 1'b1]);

    // R7
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({iss_stall, wp_stall, iss_grant}) <= 1);

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        iss_grant |=> pend[$past(iss_dst)]);

    // R8
    iadd_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_grant && (iss_unit == 2'd0) && (LAT_IADD == 1)) |-> ##2 (wb_valid && (wb_tag == $past(iss_dst, 2))));

endmodule

bind hazard_scoreboard hs_checker #(
    .TAG_W(TAG_W), .NREG(NREG), .DEPTH(DEPTH), .LW(LW), .LAT_IADD(LAT_IADD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dec_valid (dec_valid),
    .dec_dst   (dec_dst),
    .dec_stall (dec_stall),
    .iss_grant (iss_grant),
    .iss_stall (iss_stall),
    .wp_stall  (wp_stall),
    .iss_unit  (iss_unit),
    .iss_dst   (iss_dst),
    .iss_use_a (iss_use_a),
    .iss_src_a (iss_src_a),
    .iss_lat   (iss_lat),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .pend      (pend),
    .busy      (busy)
);

// File: tb/tb_hazard_scoreboard.sv
`timescale 1ns/1ps
module tb_hazard_scoreboard;

    logic       clk = 1'b0;
    logic       rst;
    logic       dec_valid, dec_use_a, dec_use_b;
    logic [5:0] dec_dst, dec_src_a, dec_src_b;
    logic       iss_valid, iss_use_a, iss_use_b;
    logic [1:0] iss_unit;
    logic [5:0] iss_dst, iss_src_a, iss_src_b;
    logic       dec_stall, iss_stall, wp_stall, iss_grant, wb_valid;
    logic [5:0] wb_tag;

    always #10 clk = ~clk;

    hazard_scoreboard dut (
        .clk(clk), .rst(rst),
        .dec_valid(dec_valid), .dec_dst(dec_dst), .dec_src_a(dec_src_a), .dec_use_a(dec_use_a),
        .dec_src_b(dec_src_b), .dec_use_b(dec_use_b),
        .iss_valid(iss_valid), .iss_unit(iss_unit), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_use_a(iss_use_a), .iss_src_b(iss_src_b), .iss_use_b(iss_use_b),
        .dec_stall(dec_stall), .iss_stall(iss_stall), .wp_stall(wp_stall), .iss_grant(iss_grant),
        .wb_valid(wb_valid), .wb_tag(wb_tag)
    );

    typedef struct {
        bit       v;
        bit [1:0] unit;
        bit [5:0] dst, sa, sb;
        bit       ua, ub;
    } ins_t;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    bit   pend_m [64];
    int   wq_cyc [$];
    bit [5:0] wq_tag [$];
    ins_t prog [$];
    ins_t dec_i, iss_i;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic ins_t mk(bit [1:0] u, bit [5:0] d, bit [5:0] a, bit ua, bit [5:0] b, bit ub);
        ins_t x;
        x.v = 1; x.unit = u; x.dst = d; x.sa = a; x.ua = ua; x.sb = b; x.ub = ub;
        return x;
    endfunction

    function automatic bit [5:0] rtag();
        return {1'($urandom % 2), 3'b000, 2'($urandom % 4)};
    endfunction

    function automatic ins_t next_ins();
        ins_t x;
        if (prog.size() > 0) return prog.pop_front();
        x = mk(2'($urandom % 4), rtag(), rtag(), 1'($urandom % 2), rtag(), 1'($urandom % 2));
        x.v = ($urandom % 5) != 0;
        return x;
    endfunction

    function automatic int lat_of(bit [1:0] u);
        return (u == 2'd1 || u == 2'd2) ? 3 : 1;
    endfunction

    task automatic drive();
        dec_valid = dec_i.v; dec_dst = dec_i.dst; dec_src_a = dec_i.sa; dec_use_a = dec_i.ua;
        dec_src_b = dec_i.sb; dec_use_b = dec_i.ub;
        iss_valid = iss_i.v; iss_unit = iss_i.unit; iss_dst = iss_i.dst;
        iss_src_a = iss_i.sa; iss_use_a = iss_i.ua; iss_src_b = iss_i.sb; iss_use_b = iss_i.ub;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        // A short in-order program first: two loads, a dependent fp add, an integer add.
        prog.push_back(mk(2'd1, 6'h21, 6'h01, 1, 6'h00, 0));
        prog.push_back(mk(2'd1, 6'h22, 6'h01, 1, 6'h00, 0));
        prog.push_back(mk(2'd2, 6'h21, 6'h21, 1, 6'h22, 1));
        prog.push_back(mk(2'd0, 6'h01, 6'h01, 1, 6'h00, 0));
        iss_i.v = 0;
        dec_i = next_ins();
        rst = 1'b1;
        drive();
        repeat (3) @(posedge clk);
        for (int c = 0; c < 4000; c++) begin
            bit wbv, rawa, rawb, eraw, free, egr, ewp, waw, war, bp, eds, adv;
            bit [5:0] wbt;
            int L, wi;
            string rq;
            @(negedge clk);
            rst = 1'b0;
            drive();
            #1;
            wbv = 0; wbt = 0; wi = -1;
            foreach (wq_cyc[i]) if (wq_cyc[i] == c) begin wbv = 1; wbt = wq_tag[i]; wi = i; end
            L = lat_of(iss_i.unit);
            free = 1;
            foreach (wq_cyc[i]) if (wq_cyc[i] == c + L + 1) free = 0;
            rawa = iss_i.ua && pend_m[iss_i.sa] && !(wbv && wbt == iss_i.sa);
            rawb = iss_i.ub && pend_m[iss_i.sb] && !(wbv && wbt == iss_i.sb);
            eraw = iss_i.v && (rawa || rawb);
            egr  = iss_i.v && !eraw && free;
            ewp  = iss_i.v && !eraw && !free;
            waw  = pend_m[dec_i.dst] || (iss_i.v && iss_i.dst == dec_i.dst);
            war  = iss_i.v && ((iss_i.ua && iss_i.sa == dec_i.dst) || (iss_i.ub && iss_i.sb == dec_i.dst));
            bp   = iss_i.v && !egr;
            eds  = dec_i.v && (waw || war || bp);

            rq = (c == 0) ? "R1" : (dec_i.v && waw) ? "R2" : (dec_i.v && war) ? "R3" : "R4";
            chk(rq, "dec_stall", int'(dec_stall), int'(eds));
            if (c == 0) rq = "R1";
            else if (iss_i.v && wbv && ((iss_i.ua && wbt == iss_i.sa) || (iss_i.ub && wbt == iss_i.sb))) rq = "R6";
            else if (iss_i.v && ((!iss_i.ua && pend_m[iss_i.sa]) || (!iss_i.ub && pend_m[iss_i.sb]))) rq = "R10";
            else if (iss_i.v && (pend_m[iss_i.sa ^ 6'h20] || pend_m[iss_i.sb ^ 6'h20])) rq = "R9";
            else rq = "R5";
            chk(rq, "iss_stall", int'(iss_stall), int'(eraw));
            chk((c == 0) ? "R1" : "R7", "wp_stall", int'(wp_stall), int'(ewp));
            chk((c == 0) ? "R1" : "R7", "iss_grant", int'(iss_grant), int'(egr));
            chk((c == 0) ? "R1" : "R8", "wb_valid", int'(wb_valid), int'(wbv));
            if (wbv) chk("R8", "wb_tag", int'(wb_tag), int'(wbt));

            if (wbv) begin
                pend_m[wbt] = 0;
                wq_cyc.delete(wi);
                wq_tag.delete(wi);
            end
            if (egr) begin
                pend_m[iss_i.dst] = 1;
                wq_cyc.push_back(c + L + 1);
                wq_tag.push_back(iss_i.dst);
            end
            adv = dec_i.v && !eds;
            if (!iss_i.v || egr) begin
                iss_i = dec_i;
                iss_i.v = adv;
            end
            if (adv || !dec_i.v) dec_i = next_ins();
        end
        done = 1;
        finish_run();
    end

endmodule